// File: doc/BRIEF.md
# Volume Transition Controller

This block owns the applied attenuation of a stereo output path. Each channel has a target level, taken from an 8-bit volume code or forced to full attenuation by a mute flag. The block moves the applied level toward that target in one of four ways, picked by a 2-bit transition mode. It can jump at once. It can jump on a signal zero crossing. It can ramp one eighth of a decibel per sample frame. It can ramp with every single step waiting for its own zero crossing. When a gated change sees no crossing, a timeout built on a shared 9-bit frame counter forces it through. Each channel detects its own crossings and keeps its own timeout, so one channel can move while the other is still waiting.

The block also registers each channel's signed sample on the frame strobe and can invert its polarity, one bit per channel. A downstream gain stage reads the applied level, which is in 1/8 dB units, together with the corrected samples. A single-volume lock makes both channels follow the channel A code.

Top module: `vol_transition_ctrl`

## Requirements
- R1: While `rst` is high, at the next clock edge both applied levels become 0 and both sample outputs become 0.
- R2: With mode 2'b00 (immediate), each applied level equals its target on the clock after the settings are presented, whether or not a frame strobe is present.
- R3: With mode 2'b10 (ramp), each frame strobe moves a level that differs from its target by exactly one unit (1/8 dB) toward the target. In modes other than 2'b00, a cycle without a strobe leaves the level unchanged.
- R4: With mode 2'b01 (zero cross), a strobe sets the level to the target only on a zero crossing. A zero crossing means the sample's sign bit differs from that of the previous strobed sample, or the sample is exactly zero. The previous sign is positive after reset.
- R5: In modes 2'b01 and 2'b11, a pending change that sees no zero crossing is applied on the second wrap of a free-running 9-bit strobe counter after it became pending. This falls 512 to 1024 strobes after the change became pending.
- R6: Zero-crossing detection and timeout state are kept per channel. A crossing on one channel never moves the other channel.
- R7: When `lock_single` is 1, both channels take their target from `vol_code_a`. When it is 0, channel B uses `vol_code_b`.
- R8: With mode 2'b11 (ramp and zero cross), a strobe moves the level one unit toward the target only on a zero crossing or on the timeout.
- R9: The target is the volume code times 4, so a code counts in 1/2 dB. An active mute sets the target to 1020 whatever the code, and mute and unmute take the selected transition.
- R10: When a channel's invert bit is 1, its sample output takes the negated sample on the clock after a strobe. The most negative value saturates to the most positive. Without a strobe the output holds.
- R11: When the invert bit is 0, the sample output takes the sample unchanged on the clock after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vol_code_a | input | 8 | Channel A attenuation code, 1/2 dB per unit |
| vol_code_b | input | 8 | Channel B attenuation code |
| mute_a | input | 1 | Mute request, channel A |
| mute_b | input | 1 | Mute request, channel B |
| lock_single | input | 1 | Both channels follow the channel A code |
| xmode | input | 2 | Transition mode: 00 immediate, 01 zero cross, 10 ramp, 11 ramp with zero cross |
| inv_a | input | 1 | Invert polarity of channel A |
| inv_b | input | 1 | Invert polarity of channel B |
| frame_stb | input | 1 | One pulse per sample frame, samples valid |
| smp_a | input | 24 | Signed sample, channel A |
| smp_b | input | 24 | Signed sample, channel B |
| level_a | output | 10 | Applied attenuation, channel A, 1/8 dB units |
| level_b | output | 10 | Applied attenuation, channel B, 1/8 dB units |
| out_a | output | 24 | Polarity-corrected sample, channel A |
| out_b | output | 24 | Polarity-corrected sample, channel B |

## Verification
A wrong stored sign bit shows on the very next gated strobe: the level either moves when the sample held its sign or stays put across a true crossing. A wrong timeout arm flag or a wrong frame counter only shows hundreds of strobes later, as a forced change that lands outside the 512-to-1024 window. The bench therefore holds a silent signal long enough to reach a wrap. A wrong step direction or step size shows on the first ramp strobe. The reference model catches all of these on the cycle they occur.

// File: rtl/vtc_pkg.sv
package vtc_pkg;
  typedef enum logic [1:0] {
    XM_DIRECT    = 2'b00,
    XM_ZERO      = 2'b01,
    XM_RAMP      = 2'b10,
    XM_RAMP_ZERO = 2'b11
  } xmode_e;

  localparam int FRAC_SHIFT = 2;
  localparam int NUM_CH     = 2;
endpackage

// File: rtl/vtc_target_sel.sv
module vtc_target_sel
  import vtc_pkg::*;
#(
  parameter int CODE_W = 8,
  localparam int LVL_W = CODE_W + FRAC_SHIFT
) (
  input  logic [NUM_CH-1:0][CODE_W-1:0] codes,
  input  logic [NUM_CH-1:0]             mutes,
  input  logic                          lock,
  output logic [NUM_CH-1:0][LVL_W-1:0]  targets
);
  localparam logic [LVL_W-1:0] MUTE_LVL = {{CODE_W{1'b1}}, {FRAC_SHIFT{1'b0}}};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_tgt
    logic [CODE_W-1:0] pick;
    assign pick = lock ? codes[0] : codes[c];
    assign targets[c] = mutes[c] ? MUTE_LVL : {pick, {FRAC_SHIFT{1'b0}}};
  end
endmodule

// File: rtl/vtc_frame_timer.sv
module vtc_frame_timer #(
  parameter int TMO_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_stb,
  output logic wrap
);
  logic [TMO_W-1:0] cnt;

  assign wrap = frame_stb && (cnt == '1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (frame_stb) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/vtc_chan.sv
module vtc_chan
  import vtc_pkg::*;
#(
  parameter int SMP_W = 24,
  parameter int LVL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  xmode_e           mode,
  input  logic             frame_stb,
  input  logic             wrap,
  input  logic [LVL_W-1:0] tgt,
  input  logic [SMP_W-1:0] smp,
  output logic [LVL_W-1:0] level
);
  logic             prev_neg;
  logic             armed;
  logic             differs;
  logic             crossing;
  logic             timed_out;
  logic             may_move;
  logic [LVL_W-1:0] one_step;
  logic [LVL_W-1:0] level_nxt;
  logic             applied;

  assign differs   = (level != tgt);
  assign crossing  = (smp == '0) || (smp[SMP_W-1] != prev_neg);
  assign timed_out = wrap && armed;
  assign may_move  = frame_stb && differs && (crossing || timed_out);
  assign one_step  = (level < tgt) ? level + 1'b1 : level - 1'b1;

  always_comb begin
    level_nxt = level;
    unique case (mode)
      XM_DIRECT:    level_nxt = tgt;
      XM_ZERO:      if (may_move) level_nxt = tgt;
      XM_RAMP:      if (frame_stb && differs) level_nxt = one_step;
      XM_RAMP_ZERO: if (may_move) level_nxt = one_step;
    endcase
  end

  assign applied = (level_nxt != level);

  always_ff @(posedge clk) begin
    if (rst) begin
      level    <= '0;
      prev_neg <= 1'b0;
      armed    <= 1'b0;
    end else begin
      level <= level_nxt;
      if (frame_stb) prev_neg <= smp[SMP_W-1];
      if (mode == XM_DIRECT || !differs) armed <= 1'b0;
      else if (frame_stb) begin
        if (applied) armed <= 1'b0;
        else if (wrap) armed <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vtc_polarity.sv
module vtc_polarity #(
  parameter int SMP_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_stb,
  input  logic             inv,
  input  logic [SMP_W-1:0] smp,
  output logic [SMP_W-1:0] out
);
  localparam logic [SMP_W-1:0] MIN_NEG = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] MAX_POS = {1'b0, {(SMP_W-1){1'b1}}};

  logic [SMP_W-1:0] negated;

  assign negated = (smp == MIN_NEG) ? MAX_POS : (~smp + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) out <= '0;
    else if (frame_stb) out <= inv ? negated : smp;
  end
endmodule

// File: rtl/vol_transition_ctrl.sv
module vol_transition_ctrl
  import vtc_pkg::*;
#(
  parameter int SMP_W  = 24,
  parameter int CODE_W = 8,
  parameter int TMO_W  = 9,
  localparam int LVL_W = CODE_W + FRAC_SHIFT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] vol_code_a,
  input  logic [CODE_W-1:0] vol_code_b,
  input  logic              mute_a,
  input  logic              mute_b,
  input  logic              lock_single,
  input  logic [1:0]        xmode,
  input  logic              inv_a,
  input  logic              inv_b,
  input  logic              frame_stb,
  input  logic [SMP_W-1:0]  smp_a,
  input  logic [SMP_W-1:0]  smp_b,
  output logic [LVL_W-1:0]  level_a,
  output logic [LVL_W-1:0]  level_b,
  output logic [SMP_W-1:0]  out_a,
  output logic [SMP_W-1:0]  out_b
);
  logic [NUM_CH-1:0][CODE_W-1:0] codes;
  logic [NUM_CH-1:0]             mutes;
  logic [NUM_CH-1:0]             invs;
  logic [NUM_CH-1:0][SMP_W-1:0]  smps;
  logic [NUM_CH-1:0][LVL_W-1:0]  targets;
  logic [NUM_CH-1:0][LVL_W-1:0]  levels;
  logic [NUM_CH-1:0][SMP_W-1:0]  outs;
  logic                          wrap;
  xmode_e                        mode;

  assign codes = {vol_code_b, vol_code_a};
  assign mutes = {mute_b, mute_a};
  assign invs  = {inv_b, inv_a};
  assign smps  = {smp_b, smp_a};
  assign mode  = xmode_e'(xmode);

  vtc_target_sel #(.CODE_W(CODE_W)) u_tgt (
    .codes   (codes),
    .mutes   (mutes),
    .lock    (lock_single),
    .targets (targets)
  );

  vtc_frame_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .wrap      (wrap)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vtc_chan #(.SMP_W(SMP_W), .LVL_W(LVL_W)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .mode      (mode),
      .frame_stb (frame_stb),
      .wrap      (wrap),
      .tgt       (targets[c]),
      .smp       (smps[c]),
      .level     (levels[c])
    );
    vtc_polarity #(.SMP_W(SMP_W)) u_pol (
      .clk       (clk),
      .rst       (rst),
      .frame_stb (frame_stb),
      .inv       (invs[c]),
      .smp       (smps[c]),
      .out       (outs[c])
    );
  end

  assign level_a = levels[0];
  assign level_b = levels[1];
  assign out_a   = outs[0];
  assign out_b   = outs[1];
endmodule

// File: rtl/vtc_checker.sv
module vtc_checker #(
  parameter int SMP_W  = 24,
  parameter int CODE_W = 8,
  parameter int LVL_W  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        xmode,
  input logic              mute_a,
  input logic              inv_a,
  input logic              frame_stb,
  input logic [SMP_W-1:0]  smp_a,
  input logic [LVL_W-1:0]  level_a,
  input logic [LVL_W-1:0]  level_b,
  input logic [SMP_W-1:0]  out_a
);
  localparam logic [LVL_W-1:0] ONE      = 1;
  localparam logic [LVL_W-1:0] MUTE_LVL = {{CODE_W{1'b1}}, 2'b00};
  localparam logic [SMP_W-1:0] MIN_NEG  = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] MAX_POS  = {1'b0, {(SMP_W-1){1'b1}}};

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (level_a == '0 && level_b == '0 && out_a == '0));

  assert_hold_without_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!frame_stb && xmode != 2'b00) |=> $stable(level_a));

  assert_single_step_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && xmode[1]) |=> (level_a == $past(level_a) ||
                                 level_a == $past(level_a) + ONE ||
                                 level_a + ONE == $past(level_a)));

  assert_mute_immediate_R9: assert property (@(posedge clk) disable iff (rst)
    (xmode == 2'b00 && mute_a) |=> (level_a == MUTE_LVL));

  assert_saturate_neg_R10: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && inv_a && smp_a == MIN_NEG) |=> (out_a == MAX_POS));

  assert_pass_through_R11: assert property (@(posedge clk) disable iff (rst)
    (frame_stb && !inv_a) |=> (out_a == $past(smp_a)));
endmodule

bind vol_transition_ctrl vtc_checker #(
  .SMP_W(SMP_W), .CODE_W(CODE_W), .LVL_W(LVL_W)
) u_vtc_chk (
  .clk       (clk),
  .rst       (rst),
  .xmode     (xmode),
  .mute_a    (mute_a),
  .inv_a     (inv_a),
  .frame_stb (frame_stb),
  .smp_a     (smp_a),
  .level_a   (level_a),
  .level_b   (level_b),
  .out_a     (out_a)
);

// File: tb/tb_vol_transition_ctrl.sv
module tb_vol_transition_ctrl;
  localparam int SW = 24;
  localparam int MIN_NEG = -(1 << 23);
  localparam int MAX_POS = (1 << 23) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] vol_code_a = '0, vol_code_b = '0;
  logic mute_a = 0, mute_b = 0, lock_single = 0, inv_a = 0, inv_b = 0, frame_stb = 0;
  logic [1:0] xmode = 2'b00;
  logic [SW-1:0] smp_a = '0, smp_b = '0;
  logic [9:0] level_a, level_b;
  logic [SW-1:0] out_a, out_b;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_lvl [2];
  int m_armed [2];
  int m_prevneg [2];
  int m_out [2];
  int m_cnt;

  always #2 clk = ~clk;

  vol_transition_ctrl dut (
    .clk(clk), .rst(rst), .vol_code_a(vol_code_a), .vol_code_b(vol_code_b),
    .mute_a(mute_a), .mute_b(mute_b), .lock_single(lock_single), .xmode(xmode),
    .inv_a(inv_a), .inv_b(inv_b), .frame_stb(frame_stb), .smp_a(smp_a), .smp_b(smp_b),
    .level_a(level_a), .level_b(level_b), .out_a(out_a), .out_b(out_b)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int tgt_of(int c);
    int code;
    code = (c == 0 || lock_single) ? int'(vol_code_a) : int'(vol_code_b);
    if ((c == 0) ? mute_a : mute_b) return 1020;
    return code * 4;
  endfunction

  task automatic model_step();
    bit roll;
    if (rst) begin
      for (int c = 0; c < 2; c++) begin
        m_lvl[c] = 0; m_armed[c] = 0; m_prevneg[c] = 0; m_out[c] = 0;
      end
      m_cnt = 0;
      return;
    end
    roll = frame_stb && (m_cnt == 511);
    if (frame_stb) m_cnt = (m_cnt + 1) % 512;
    for (int c = 0; c < 2; c++) begin
      int t, s, nl;
      bit zc, inv;
      t   = tgt_of(c);
      s   = $signed((c == 0) ? smp_a : smp_b);
      inv = (c == 0) ? inv_a : inv_b;
      zc  = (s == 0) || ((s < 0) != (m_prevneg[c] != 0));
      nl  = m_lvl[c];
      if (xmode == 2'b00) nl = t;
      else if (frame_stb && m_lvl[c] != t) begin
        bit go;
        go = (xmode == 2'b10) || zc || (roll && m_armed[c] != 0);
        if (go) nl = (xmode[1]) ? (m_lvl[c] < t ? m_lvl[c] + 1 : m_lvl[c] - 1) : t;
      end
      if (xmode == 2'b00 || m_lvl[c] == t) m_armed[c] = 0;
      else if (frame_stb) begin
        if (nl != m_lvl[c]) m_armed[c] = 0;
        else if (roll) m_armed[c] = 1;
      end
      m_lvl[c] = nl;
      if (frame_stb) begin
        m_prevneg[c] = (s < 0);
        m_out[c] = inv ? ((s == MIN_NEG) ? MAX_POS : -s) : s;
      end
    end
  endtask

  task automatic cyc(string req);
    @(posedge clk);
    #1;
    model_step();
    check(req, int'(level_a), m_lvl[0]);
    check(req, int'(level_b), m_lvl[1]);
    check(req, $signed(out_a), m_out[0]);
    check(req, $signed(out_b), m_out[1]);
  endtask

  task automatic strobe(string req, int idle);
    frame_stb = 1;
    cyc(req);
    frame_stb = 0;
    for (int i = 0; i < idle; i++) cyc(req);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    for (int i = 0; i < 3; i++) cyc("R1");
    check("R1", int'(level_a), 0);
    check("R1", int'(out_a), 0);
    rst = 0;

    vol_code_a = 8'd10; cyc("R2");
    check("R2", int'(level_a), 40);
    mute_a = 1; cyc("R9");
    check("R9", int'(level_a), 1020);
    mute_a = 0; cyc("R9");
    check("R9", int'(level_a), 40);

    vol_code_b = 8'd20; lock_single = 1; cyc("R7");
    check("R7", int'(level_b), 40);
    lock_single = 0; cyc("R7");
    check("R7", int'(level_b), 80);

    xmode = 2'b10; vol_code_a = 8'd0;
    for (int i = 0; i < 5; i++) strobe("R3", 2);
    check("R3", int'(level_a), 35);
    for (int i = 0; i < 3; i++) cyc("R3");
    check("R3", int'(level_a), 35);
    for (int i = 0; i < 40; i++) strobe("R3", 1);
    check("R3", int'(level_a), 0);

    mute_b = 1;
    for (int i = 0; i < 3; i++) strobe("R9", 1);
    check("R9", int'(level_b), 83);

    xmode = 2'b01; mute_b = 0; vol_code_a = 8'd50;
    smp_a = 24'sd7; smp_b = 24'sd7;
    for (int i = 0; i < 3; i++) strobe("R4", 1);
    check("R4", int'(level_a), 0);
    smp_a = -24'sd3;
    strobe("R6", 1);
    check("R4", int'(level_a), 200);
    check("R6", int'(level_b), 83);
    smp_b = '0;
    strobe("R4", 1);
    check("R4", int'(level_b), 80);

    xmode = 2'b11; vol_code_a = 8'd52;
    smp_a = 24'sd4; strobe("R8", 1);
    check("R8", int'(level_a), 201);
    strobe("R8", 1);
    check("R8", int'(level_a), 201);
    smp_a = -24'sd4; strobe("R8", 1);
    check("R8", int'(level_a), 202);

    smp_a = 24'sd5; smp_b = 24'sd5;
    strobe("R5", 1); strobe("R5", 1);
    xmode = 2'b01; vol_code_a = 8'd30;
    n = 0;
    frame_stb = 1;
    while (int'(level_a) == m_lvl[0] && m_lvl[0] != 120 && n < 1100) begin
      cyc("R5");
      n++;
    end
    frame_stb = 0;
    cyc("R5");
    check("R5", int'(level_a), 120);
    check("R5", (n >= 512 && n <= 1024) ? 1 : 0, 1);

    inv_a = 1; smp_a = 24'sd1000; strobe("R10", 0);
    check("R10", $signed(out_a), -1000);
    smp_a = 24'h800000; strobe("R10", 0);
    check("R10", $signed(out_a), MAX_POS);
    smp_a = 24'sd9; cyc("R10");
    check("R10", $signed(out_a), MAX_POS);
    inv_a = 0; smp_a = 24'h800000; strobe("R11", 0);
    check("R11", $signed(out_a), MIN_NEG);
    inv_b = 1; smp_b = 24'sd77; strobe("R10", 1);
    check("R10", $signed(out_b), -77);

    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule